// File: doc/BRIEF.md
# SPI Slave Byte Controller

This block is an 8-bit serial peripheral interface slave with a small register window for a local host. An external master drives the serial clock, the slave-select line and the master-to-slave data line. The block samples all three in its own system clock domain, recovers the clock edges, assembles each incoming byte and shifts a host-supplied byte back out on the slave-to-master line. The system clock must run at least four times faster than the serial clock.

The host sees three registers: a data register, a control register and a read-only status register. The data register is written to supply the next outgoing byte and read to collect the last received byte. The control register holds an enable bit, a master-select bit (the slave works only when it is clear), an interrupt enable and the clock polarity and phase bits. The status register reports a byte-complete flag and an overrun flag.

The byte-complete flag is cleared in two steps. The host first reads status while the flag is set, then reads or writes the data register. Until the status read has happened, writes to the data register are dropped. If a second byte finishes before the flag has been cleared, the overrun flag is set and the newer byte is discarded.

Top module: `spi_slave_ctl`

## Requirements
- R1: After reset the data, control and status registers all read 0, the interrupt request is low and the MISO output enable is low.
- R2: A byte written to the data register (address 0) is sent on MISO most significant bit first during the next transfer.
- R3: After eight bits have been captured, status bit 0 (byte-complete) is set, and a read of the data register returns the received byte, first bit received in bit 7.
- R4: The slave takes part in transfers only when control bit 0 (enable) is 1 and control bit 1 (master-select) is 0. Otherwise MISO output enable stays low and no byte completes.
- R5: The interrupt request is high exactly while status bit 0 is set and control bit 2 (interrupt enable) is 1.
- R6: Status bit 0 clears only after a status read (address 2) made while it is set, followed by a data register read or write. A data register access with no such status read before it leaves the flag set.
- R7: While status bit 0 is set and status has not yet been read, a write to the data register is ignored and does not change the next byte sent.
- R8: A byte that completes while status bit 0 is still set sets status bit 1 (overrun) and is dropped, so the data register keeps the earlier byte. The overrun bit is cleared by the same sequence that clears status bit 0.
- R9: All four clock modes work. Control bit 3 is the clock polarity (the idle clock level), and control bit 4 is the phase (0 samples on the edge leaving idle, 1 samples on the edge returning to idle).
- R10: With phase 1, slave-select may stay low across consecutive bytes. Each byte completes separately, and a data write made between bytes is sent in the following byte.
- R11: While slave-select is high, MISO output enable is low and the bit counter returns to zero. A byte cut short by slave-select rising does not complete, and the next transfer starts at bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Host access strobe, one cycle per access |
| bus_we_i | input | 1 | Host write (1) or read (0) |
| bus_addr_i | input | 2 | Register select: 0 data, 1 control, 2 status |
| bus_wdata_i | input | 8 | Host write data |
| bus_rdata_o | output | 8 | Host read data, valid in the access cycle |
| sck_i | input | 1 | Serial clock from the external master |
| mosi_i | input | 1 | Serial data from the master |
| ss_n_i | input | 1 | Slave select, active low |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Output enable for MISO |
| irq_o | output | 1 | Interrupt request |

## Verification
A change on SCK, MOSI or SS takes effect three system clock edges later: two synchroniser stages, then the state register. The byte-complete flag, the received byte, the MISO bit and the output enable therefore settle three cycles after the serial edge that causes them. The bench holds each serial clock level for eight system cycles and reads MISO just before it makes the next sampling edge. That leaves five cycles of margin. Register reads return data in the cycle of the access and are sampled before the closing clock edge, while their side effects (arming, clearing, loading) are checked by the following accesses and transfers. All serial and bus inputs change on the falling system clock edge.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] A_CTL  = 2'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd2;

  // control register layout, bit 0 = en ... bit 4 = cpha
  typedef struct packed {
    logic cpha;
    logic cpol;
    logic ie;
    logic msel;
    logic en;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
  localparam int STAT_W = 2;
endpackage

// File: rtl/spi_slave_sync.sv
module spi_slave_sync #(
  parameter int              W       = 3,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= RST_VAL[i];
        s2_q <= RST_VAL[i];
      end else begin
        s1_q <= din[i];
        s2_q <= s1_q;
      end
    end
    assign dout[i] = s2_q;
  end
endmodule

// File: rtl/spi_slave_shift.sv
module spi_slave_shift #(
  parameter int DW = 8,
  localparam int CW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          sck_s,
  input  logic          mosi_s,
  input  logic          load_en,
  input  logic [DW-1:0] load_data,
  input  logic [DW-1:0] tx_hold,
  output logic          miso,
  output logic          done,
  output logic [DW-1:0] rx_byte,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic          sck_d_q;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [DW-1:0] rx_q, rx_n;
  logic [DW-1:0] tx_q, tx_n;
  logic          rise, fall, lead, trail, samp, shft;

  assign rise  = sck_s & ~sck_d_q;
  assign fall  = ~sck_s & sck_d_q;
  assign lead  = cpol ? fall : rise;
  assign trail = cpol ? rise : fall;
  assign samp  = active & (cpha ? trail : lead);
  assign shft  = active & (cpha ? lead : trail);

  always_comb begin
    cnt_n = cnt_q;
    rx_n  = rx_q;
    tx_n  = tx_q;
    done  = 1'b0;
    if (!active) begin
      cnt_n = '0;
      tx_n  = tx_hold;
    end else begin
      if (samp) begin
        rx_n = {rx_q[DW-2:0], mosi_s};
        if (cnt_q == LAST) begin
          cnt_n = '0;
          done  = 1'b1;
          tx_n  = tx_hold;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end else if (shft && cnt_q != '0) begin
        tx_n = {tx_q[DW-2:0], 1'b0};
      end
      if (load_en && cnt_q == '0 && !samp) begin
        tx_n = load_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d_q <= 1'b0;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
    end else begin
      sck_d_q <= sck_s;
      cnt_q   <= cnt_n;
      rx_q    <= rx_n;
      tx_q    <= tx_n;
    end
  end

  assign miso    = tx_q[DW-1];
  assign rx_byte = {rx_q[DW-2:0], mosi_s};
  assign cnt     = cnt_q;
endmodule

// File: rtl/spi_slave_regs.sv
module spi_slave_regs
  import spi_slave_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              done,
  input  logic [DW-1:0]     rx_byte,
  output ctl_t              ctl,
  output logic [DW-1:0]     tx_hold,
  output logic              load_en,
  output logic              flag,
  output logic              ovr,
  output logic              armed,
  output logic [DW-1:0]     rx_data
);
  ctl_t          ctl_q, ctl_n;
  logic [DW-1:0] tx_q, tx_n;
  logic [DW-1:0] rx_q, rx_n;
  logic          flag_q, flag_n;
  logic          ovr_q, ovr_n;
  logic          arm_q, arm_n;
  logic          rd_stat, data_acc, data_wr, ctl_wr, wr_ok, clr;
  logic [CTL_W-1:0] ctl_bits;

  assign rd_stat  = bus_sel & ~bus_we & (bus_addr == A_STAT);
  assign data_acc = bus_sel & (bus_addr == A_DATA);
  assign data_wr  = data_acc & bus_we;
  assign ctl_wr   = bus_sel & bus_we & (bus_addr == A_CTL);
  assign wr_ok    = data_wr & (~flag_q | arm_q);
  assign clr      = data_acc & arm_q;

  always_comb begin
    ctl_n  = ctl_q;
    tx_n   = tx_q;
    rx_n   = rx_q;
    flag_n = flag_q;
    ovr_n  = ovr_q;
    arm_n  = arm_q;
    if (ctl_wr) ctl_n = ctl_t'(bus_wdata[CTL_W-1:0]);
    if (wr_ok)  tx_n  = bus_wdata;
    if (rd_stat && flag_q) arm_n = 1'b1;
    if (clr) begin
      flag_n = 1'b0;
      ovr_n  = 1'b0;
      arm_n  = 1'b0;
    end
    if (done) begin
      if (flag_n) begin
        ovr_n = 1'b1;
      end else begin
        flag_n = 1'b1;
        rx_n   = rx_byte;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      flag_q <= 1'b0;
      ovr_q  <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      ctl_q  <= ctl_n;
      tx_q   <= tx_n;
      rx_q   <= rx_n;
      flag_q <= flag_n;
      ovr_q  <= ovr_n;
      arm_q  <= arm_n;
    end
  end

  assign ctl_bits = ctl_q;

  always_comb begin
    unique case (bus_addr)
      A_DATA:  bus_rdata = rx_q;
      A_CTL:   bus_rdata = {{(DW-CTL_W){1'b0}}, ctl_bits};
      A_STAT:  bus_rdata = {{(DW-STAT_W){1'b0}}, ovr_q, flag_q};
      default: bus_rdata = '0;
    endcase
  end

  assign ctl     = ctl_q;
  assign tx_hold = tx_q;
  assign load_en = wr_ok;
  assign flag    = flag_q;
  assign ovr     = ovr_q;
  assign armed   = arm_q;
  assign rx_data = rx_q;
endmodule

// File: rtl/spi_slave_ctl.sv
module spi_slave_ctl
  import spi_slave_pkg::*;
#(
  parameter int DW = 8,
  localparam int CW = $clog2(DW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              ss_n_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic              irq_o
);
  logic [1:0]    rst_pipe_q;
  logic          rst_n_int;
  logic [2:0]    pins_s;
  logic          sck_s, mosi_s, ss_s;
  logic          active;
  ctl_t          ctl;
  logic [DW-1:0] tx_hold, rx_byte, rx_data;
  logic          load_en, done, miso, flag, ovr, armed;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  spi_slave_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .din   ({ss_n_i, mosi_i, sck_i}),
    .dout  (pins_s)
  );
  assign {ss_s, mosi_s, sck_s} = pins_s;

  assign active = ctl.en & ~ctl.msel & ~ss_s;

  spi_slave_shift #(.DW(DW)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .active    (active),
    .cpol      (ctl.cpol),
    .cpha      (ctl.cpha),
    .sck_s     (sck_s),
    .mosi_s    (mosi_s),
    .load_en   (load_en),
    .load_data (bus_wdata_i),
    .tx_hold   (tx_hold),
    .miso      (miso),
    .done      (done),
    .rx_byte   (rx_byte),
    .cnt       (cnt)
  );

  spi_slave_regs #(.DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .bus_sel   (bus_sel_i),
    .bus_we    (bus_we_i),
    .bus_addr  (bus_addr_i),
    .bus_wdata (bus_wdata_i),
    .bus_rdata (bus_rdata_o),
    .done      (done),
    .rx_byte   (rx_byte),
    .ctl       (ctl),
    .tx_hold   (tx_hold),
    .load_en   (load_en),
    .flag      (flag),
    .ovr       (ovr),
    .armed     (armed),
    .rx_data   (rx_data)
  );

  assign miso_o    = miso;
  assign miso_oe_o = active;
  assign irq_o     = flag & ctl.ie;
endmodule

// File: rtl/spi_slave_chk.sv
module spi_slave_chk #(
  parameter int DW = 8,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel_i,
  input logic          bus_we_i,
  input logic [1:0]    bus_addr_i,
  input logic          miso_oe_o,
  input logic          irq_o,
  input logic          ctl_en,
  input logic          flag,
  input logic          ovr,
  input logic          armed,
  input logic          done,
  input logic [DW-1:0] rx_data,
  input logic [DW-1:0] tx_hold,
  input logic [CW-1:0] cnt
);
  p_oe_off_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |-> !miso_oe_o);

  p_irq_needs_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> flag);

  p_flag_on_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> flag);

  p_clear_needs_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(armed));

  p_write_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel_i && bus_we_i && bus_addr_i == 2'd0 && flag && !armed) |=> $stable(tx_hold));

  p_ovr_has_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |-> flag);

  p_keep_first_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && flag) |=> $stable(rx_data));

  p_cnt_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !miso_oe_o |=> cnt == '0);
endmodule

bind spi_slave_ctl spi_slave_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_sel_i  (bus_sel_i),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .miso_oe_o  (miso_oe_o),
  .irq_o      (irq_o),
  .ctl_en     (ctl.en),
  .flag       (flag),
  .ovr        (ovr),
  .armed      (armed),
  .done       (done),
  .rx_data    (rx_data),
  .tx_hold    (tx_hold),
  .cnt        (cnt)
);

// File: tb/tb_spi_slave_ctl.sv
module tb_spi_slave_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       sck = 1'b0, mosi = 1'b0, ss_n = 1'b1;
  logic       miso, miso_oe, irq;
  logic       cpol = 1'b0, cpha = 1'b0;
  int         n_chk = 0, n_err = 0;
  logic [7:0] got, mi;

  always #2 clk = ~clk;

  spi_slave_ctl dut (
    .clk(clk), .rst_n(rst_n),
    .bus_sel_i(bus_sel), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .sck_i(sck), .mosi_i(mosi), .ss_n_i(ss_n),
    .miso_o(miso), .miso_oe_o(miso_oe), .irq_o(irq)
  );

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: run did not end, act=hung exp=done");
    summary();
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (8) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  // control byte: bit0 en, bit1 msel, bit2 ie, bit3 cpol, bit4 cpha
  task automatic cfg(input logic pol, input logic pha, input logic ie, input logic ms);
    ss_n = 1'b1; cpol = pol; cpha = pha; sck = pol;
    half();
    bus_wr(2'd1, {3'b000, pha, pol, ie, ms, 1'b1});
  endtask

  task automatic xfer(input logic [7:0] mo, input int nbits, input bit keep,
                      output logic [7:0] rx);
    rx = 8'h00;
    if (ss_n) begin ss_n = 1'b0; half(); end
    for (int i = 7; i > 7 - nbits; i--) begin
      if (!cpha) begin
        mosi = mo[i]; half();
        rx = {rx[6:0], miso};
        sck = ~cpol; half();
        sck = cpol;
      end else begin
        sck = ~cpol; mosi = mo[i]; half();
        rx = {rx[6:0], miso};
        sck = cpol; half();
      end
    end
    if (!cpha) half();
    if (!keep) begin ss_n = 1'b1; half(); end
  endtask

  task automatic t_reset();
    bus_rd(2'd0, got); chk("R1 data", got, 8'h00);
    bus_rd(2'd1, got); chk("R1 ctl", got, 8'h00);
    bus_rd(2'd2, got); chk("R1 status", got, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 oe", {7'd0, miso_oe}, 8'h00);
  endtask

  task automatic t_mode(input logic pol, input logic pha, input logic [7:0] tx,
                        input logic [7:0] mo);
    cfg(pol, pha, 1'b1, 1'b0);
    bus_wr(2'd0, tx);
    xfer(mo, 8, 1'b0, mi);
    chk("R2/R9 miso byte", mi, tx);
    chk("R5 irq set", {7'd0, irq}, 8'h01);
    bus_rd(2'd2, got); chk("R3 flag set", got, 8'h01);
    bus_rd(2'd0, got); chk("R3/R9 rx byte", got, mo);
    bus_rd(2'd2, got); chk("R6 flag cleared", got, 8'h00);
    chk("R5 irq clear", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_irq_mask();
    cfg(1'b0, 1'b0, 1'b0, 1'b0);
    xfer(8'h5D, 8, 1'b0, mi);
    chk("R5 irq masked", {7'd0, irq}, 8'h00);
    bus_rd(2'd2, got); chk("R5 flag without irq", got, 8'h01);
    bus_rd(2'd0, got);
  endtask

  task automatic t_clear_order();
    cfg(1'b0, 1'b0, 1'b1, 1'b0);
    xfer(8'h81, 8, 1'b0, mi);
    bus_rd(2'd0, got);
    bus_rd(2'd2, got); chk("R6 data read alone keeps flag", got, 8'h01);
    bus_rd(2'd0, got); chk("R6 rx byte", got, 8'h81);
    bus_rd(2'd2, got); chk("R6 cleared after sequence", got, 8'h00);
  endtask

  task automatic t_write_block();
    cfg(1'b0, 1'b0, 1'b1, 1'b0);
    bus_wr(2'd0, 8'h96);
    xfer(8'h11, 8, 1'b0, mi);
    bus_wr(2'd0, 8'h3C);
    bus_rd(2'd2, got); chk("R7 flag still set", got, 8'h01);
    bus_rd(2'd0, got); chk("R7 rx byte", got, 8'h11);
    xfer(8'h22, 8, 1'b0, mi);
    chk("R7 blocked write not sent", mi, 8'h96);
    bus_rd(2'd2, got);
    bus_rd(2'd0, got);
  endtask

  task automatic t_overrun();
    cfg(1'b1, 1'b0, 1'b1, 1'b0);
    bus_wr(2'd0, 8'h0F);
    xfer(8'hA1, 8, 1'b0, mi);
    xfer(8'hB2, 8, 1'b0, mi);
    bus_rd(2'd2, got); chk("R8 overrun status", got, 8'h03);
    bus_rd(2'd0, got); chk("R8 first byte kept", got, 8'hA1);
    bus_rd(2'd2, got); chk("R8 overrun cleared", got, 8'h00);
  endtask

  task automatic t_stream();
    logic [7:0] m1;
    logic [7:0] m2;
    cfg(1'b1, 1'b1, 1'b1, 1'b0);
    bus_wr(2'd0, 8'h5A);
    xfer(8'hC3, 8, 1'b1, m1);
    chk("R10 first miso", m1, 8'h5A);
    bus_rd(2'd2, got); chk("R10 first flag", got, 8'h01);
    bus_wr(2'd0, 8'hE7);
    bus_rd(2'd2, got); chk("R10 cleared by write", got, 8'h00);
    xfer(8'h3E, 8, 1'b0, m2);
    chk("R10 second miso", m2, 8'hE7);
    bus_rd(2'd2, got); chk("R10 second flag", got, 8'h01);
    bus_rd(2'd0, got); chk("R10 second rx", got, 8'h3E);
  endtask

  task automatic t_abort();
    cfg(1'b0, 1'b1, 1'b1, 1'b0);
    bus_wr(2'd0, 8'hB4);
    xfer(8'hFF, 3, 1'b0, mi);
    chk("R11 oe low with ss high", {7'd0, miso_oe}, 8'h00);
    bus_rd(2'd2, got); chk("R11 partial byte no flag", got, 8'h00);
    xfer(8'h4B, 8, 1'b0, mi);
    chk("R11 restart miso", mi, 8'hB4);
    bus_rd(2'd2, got); chk("R11 restart flag", got, 8'h01);
    bus_rd(2'd0, got); chk("R11 restart rx", got, 8'h4B);
  endtask

  task automatic t_disabled();
    cfg(1'b0, 1'b0, 1'b1, 1'b1);
    xfer(8'h77, 8, 1'b1, mi);
    chk("R4 oe low with master-select", {7'd0, miso_oe}, 8'h00);
    ss_n = 1'b1; half();
    bus_rd(2'd2, got); chk("R4 no completion", got, 8'h00);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_mode(1'b0, 1'b0, 8'hA5, 8'h3C);
    t_mode(1'b0, 1'b1, 8'h1E, 8'hD2);
    t_mode(1'b1, 1'b0, 8'h80, 8'h01);
    t_mode(1'b1, 1'b1, 8'h6B, 8'hF0);
    t_irq_mask();
    t_clear_order();
    t_write_block();
    t_overrun();
    t_stream();
    t_abort();
    t_disabled();
    summary();
  end
endmodule